// File: doc/BRIEF.md
# ADC Output Status Monitor

This block sits between a decimation filter and a serial readout port. Each cycle in which the filter presents a result (a signed word wider than the output, with a valid strobe and an arithmetic-overflow flag), the block registers a 24-bit two's-complement output word. Results beyond the 24-bit span are saturated, and overflowed results are forced to full scale according to their sign.

Alongside the data path it keeps sticky status flags. An accumulator-overflow flag, an out-of-range flag, a data-overwrite flag and an external-flag mirror are set by their events and stay set until a status read completes. A filter-settled flag is cleared by any event that disturbs the filter and returns only after a programmable number of fresh results. While the filter is unsettled, only reset can change the four sticky flags. A summary error flag (overwrite, external flag or accumulator overflow) is also driven as an active-low pin.

Top module: `adc_status_mon`

## Requirements
- R1: Each cycle with `res_valid` high yields, one clock later, `out_valid` high and `out_word` equal to the input saturated to [0x800000, 0x7FFFFF]. If `res_ovf` is also high, the word is 0x800000 when the input's sign bit is 1 and 0x7FFFFF otherwise. `out_valid` is low one clock after a cycle without `res_valid`.
- R2: A valid result with `res_ovf` high while `settled` is high sets `acc_flag` on the next clock.
- R3: `range_flag` is set after RANGE_CNT (default 4) consecutive valid results, taken while settled, that are all above +6291455 or all below -6291456. A valid in-range result restarts the run, and so does a result of the opposite polarity (which begins a new run of length 1). Cycles without `res_valid` do not break a run.
- R4: A read is open from a `rd_start` pulse until a `rd_done` pulse; if both arrive in the same cycle, the read is open. A valid result arriving while a read is open and `settled` is high sets `ovwr_flag`.
- R5: While `settled` is high and `pwr_down` is low, a high `ext_flag` sets `mflg_flag` on the next clock, and `settled` goes low on that same clock. `ext_flag` has no effect during power-down.
- R6: `err_flag` is the OR of `ovwr_flag`, `mflg_flag` and `acc_flag` (not `range_flag`); `err_n` is its inverse. Both change on the same clock as the flags.
- R7: A `stat_rd_done` pulse while settled clears all four sticky flags. An event arriving in the same cycle still sets its flag.
- R8: `settled` goes low after reset, `sync_in`, `cfg_change`, any cycle of `pwr_down`, and the first cycle after `pwr_down` falls. It rises on the clock of the SETTLE_CNT-th valid result that follows, with no such event in between.
- R9: While `settled` is low, `acc_flag`, `range_flag`, `ovwr_flag` and `mflg_flag` hold their values, including through `stat_rd_done`.
- R10: A synchronous active-high `rst` clears `out_word`, `out_valid`, every flag, `err_flag` and the read tracker, and sets `err_n` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| res_valid | input | 1 | Filter result strobe |
| res_data | input | IN_W | Signed filter result |
| res_ovf | input | 1 | Filter arithmetic overflow/underflow |
| rd_start | input | 1 | Data read started |
| rd_done | input | 1 | Data read finished |
| stat_rd_done | input | 1 | Status read finished |
| sync_in | input | 1 | Restart of the filter convolution |
| cfg_change | input | 1 | Filter configuration changed |
| pwr_down | input | 1 | Power-down request |
| ext_flag | input | 1 | External flag input |
| out_word | output | OUT_W | Clipped output word |
| out_valid | output | 1 | Output word updated |
| acc_flag | output | 1 | Accumulator overflow seen |
| range_flag | output | 1 | Input out of range |
| ovwr_flag | output | 1 | Unread data overwritten |
| mflg_flag | output | 1 | External flag captured |
| settled | output | 1 | Filter settled |
| err_flag | output | 1 | Summary error |
| err_n | output | 1 | Summary error, active low |

## Verification
The bench builds the block with SETTLE_CNT set to 2 and the other parameters at their defaults. This keeps every resettling sequence short, so the flag-freeze window and the settling count can be checked from both sides. The clipping sweep visits every input within three codes of the saturation limits, the range limits, zero and the extremes of the 26-bit input. The range runs cover runs that are one short, runs broken by an in-range value, and runs broken by a polarity reversal.

// File: rtl/adc_mon_pkg.sv
package adc_mon_pkg;

  typedef enum logic [1:0] {
    POL_NONE = 2'd0,
    POL_HI   = 2'd1,
    POL_LO   = 2'd2
  } pol_t;

  typedef struct packed {
    logic acc;
    logic rng;
    logic ovwr;
    logic mflg;
  } flag_t;

endpackage

// File: rtl/adc_word_clip.sv
module adc_word_clip #(
  parameter int IN_W  = 26,
  parameter int OUT_W = 24
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    res_valid,
  input  logic signed [IN_W-1:0]  res_data,
  input  logic                    res_ovf,
  output logic [OUT_W-1:0]        out_word,
  output logic                    out_valid
);

  localparam logic signed [IN_W-1:0] SAT_HI =
    {{(IN_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
  localparam logic signed [IN_W-1:0] SAT_LO =
    {{(IN_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};
  localparam logic [OUT_W-1:0] FS_POS = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] FS_NEG = {1'b1, {(OUT_W-1){1'b0}}};

  logic [OUT_W-1:0] word_nxt;

  always_comb begin
    if (res_ovf)
      word_nxt = res_data[IN_W-1] ? FS_NEG : FS_POS;
    else if (res_data > SAT_HI)
      word_nxt = FS_POS;
    else if (res_data < SAT_LO)
      word_nxt = FS_NEG;
    else
      word_nxt = res_data[OUT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_word  <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= res_valid;
      if (res_valid) out_word <= word_nxt;
    end
  end

  p_valid_follow_r1: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> out_valid);
  p_valid_idle_r1: assert property (@(posedge clk) disable iff (rst)
    !res_valid |=> !out_valid);
  p_inrange_pass_r1: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_ovf && res_data <= SAT_HI && res_data >= SAT_LO)
      |=> out_word == $past(res_data[OUT_W-1:0]));
  p_ovf_pos_r1: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_ovf && !res_data[IN_W-1]) |=> out_word == FS_POS);
  p_ovf_neg_r1: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_ovf && res_data[IN_W-1]) |=> out_word == FS_NEG);

endmodule

// File: rtl/adc_range_watch.sv
module adc_range_watch
  import adc_mon_pkg::*;
#(
  parameter int IN_W      = 26,
  parameter int RANGE_CNT = 4,
  parameter int LIM_HI    = 6291455,
  parameter int LIM_LO    = -6291456
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   res_valid,
  input  logic signed [IN_W-1:0] res_data,
  output logic                   range_hit
);

  localparam int CW = $clog2(RANGE_CNT + 1);
  localparam logic signed [IN_W-1:0] HI_B = IN_W'(LIM_HI);
  localparam logic signed [IN_W-1:0] LO_B = IN_W'(LIM_LO);
  localparam logic [CW-1:0] CNT_TOP = CW'(RANGE_CNT);

  pol_t          pol_q, pol_n;
  logic [CW-1:0] cnt_q, cnt_n, cnt_inc;
  logic          is_hi, is_lo;

  always_comb begin
    is_hi   = res_data > HI_B;
    is_lo   = res_data < LO_B;
    cnt_inc = (cnt_q == CNT_TOP) ? cnt_q : cnt_q + 1'b1;
    pol_n   = pol_q;
    cnt_n   = cnt_q;
    if (res_valid) begin
      if (is_hi) begin
        pol_n = POL_HI;
        cnt_n = (pol_q == POL_HI) ? cnt_inc : CW'(1);
      end else if (is_lo) begin
        pol_n = POL_LO;
        cnt_n = (pol_q == POL_LO) ? cnt_inc : CW'(1);
      end else begin
        pol_n = POL_NONE;
        cnt_n = '0;
      end
    end
    range_hit = res_valid && (cnt_n == CNT_TOP);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pol_q <= POL_NONE;
      cnt_q <= '0;
    end else begin
      pol_q <= pol_n;
      cnt_q <= cnt_n;
    end
  end

  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_TOP);
  p_inrange_restart_r3: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !is_hi && !is_lo) |=> cnt_q == '0);
  p_pol_consistent_r3: assert property (@(posedge clk) disable iff (rst)
    (pol_q == POL_NONE) == (cnt_q == '0));

endmodule

// File: rtl/adc_settle_track.sv
module adc_settle_track #(
  parameter int SETTLE_CNT = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic res_valid,
  input  logic sync_in,
  input  logic cfg_change,
  input  logic pwr_down,
  input  logic mflg_set,
  output logic settled
);

  localparam int CW = $clog2(SETTLE_CNT + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(SETTLE_CNT - 1);

  logic          pd_q;
  logic          pd_leave;
  logic          clr_evt;
  logic [CW-1:0] cnt_q;

  assign pd_leave = pd_q && !pwr_down;
  assign clr_evt  = sync_in || cfg_change || pwr_down || pd_leave || mflg_set;

  always_ff @(posedge clk) begin
    if (rst) begin
      pd_q    <= 1'b0;
      settled <= 1'b0;
      cnt_q   <= '0;
    end else begin
      pd_q <= pwr_down;
      if (clr_evt) begin
        settled <= 1'b0;
        cnt_q   <= '0;
      end else if (!settled && res_valid) begin
        if (cnt_q == CNT_LAST) begin
          settled <= 1'b1;
          cnt_q   <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  p_drop_r8: assert property (@(posedge clk) disable iff (rst)
    (sync_in || cfg_change || pwr_down || mflg_set) |=> !settled);
  p_cnt_bound_r8: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_LAST);
  p_rise_needs_valid_r8: assert property (@(posedge clk) disable iff (rst)
    (!settled && !res_valid) |=> !settled);

endmodule

// File: rtl/adc_err_flags.sv
module adc_err_flags
  import adc_mon_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic settled,
  input  logic pwr_down,
  input  logic stat_clr,
  input  logic acc_evt,
  input  logic rng_evt,
  input  logic ovwr_evt,
  input  logic ext_flag,
  output logic mflg_set,
  output logic acc_flag,
  output logic range_flag,
  output logic ovwr_flag,
  output logic mflg_flag,
  output logic err_flag,
  output logic err_n
);

  flag_t f_q, f_n;

  always_comb begin
    mflg_set = settled && !pwr_down && ext_flag && !f_q.mflg;
    f_n      = f_q;
    if (settled) begin
      if (stat_clr) f_n = '0;
      if (acc_evt)  f_n.acc  = 1'b1;
      if (rng_evt)  f_n.rng  = 1'b1;
      if (ovwr_evt) f_n.ovwr = 1'b1;
      if (!pwr_down && ext_flag) f_n.mflg = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      f_q      <= '0;
      err_flag <= 1'b0;
      err_n    <= 1'b1;
    end else begin
      f_q      <= f_n;
      err_flag <= f_n.acc | f_n.ovwr | f_n.mflg;
      err_n    <= ~(f_n.acc | f_n.ovwr | f_n.mflg);
    end
  end

  assign acc_flag   = f_q.acc;
  assign range_flag = f_q.rng;
  assign ovwr_flag  = f_q.ovwr;
  assign mflg_flag  = f_q.mflg;

  p_acc_set_r2: assert property (@(posedge clk) disable iff (rst)
    (settled && acc_evt) |=> acc_flag);
  p_rng_set_r3: assert property (@(posedge clk) disable iff (rst)
    (settled && rng_evt) |=> range_flag);
  p_ovwr_set_r4: assert property (@(posedge clk) disable iff (rst)
    (settled && ovwr_evt) |=> ovwr_flag);
  p_mflg_pd_r5: assert property (@(posedge clk) disable iff (rst)
    (pwr_down && !mflg_flag) |=> !mflg_flag);
  p_err_or_r6: assert property (@(posedge clk) disable iff (rst)
    err_flag == (acc_flag | ovwr_flag | mflg_flag));
  p_err_pin_r6: assert property (@(posedge clk) disable iff (rst)
    err_n != err_flag);
  p_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (settled && stat_clr && !acc_evt && !rng_evt && !ovwr_evt && !ext_flag)
      |=> (f_q == '0));
  p_frozen_r9: assert property (@(posedge clk) disable iff (rst)
    !settled |=> $stable(f_q));

endmodule

// File: rtl/adc_status_mon.sv
module adc_status_mon #(
  parameter int IN_W       = 26,
  parameter int OUT_W      = 24,
  parameter int RANGE_CNT  = 4,
  parameter int SETTLE_CNT = 4,
  parameter int LIM_HI     = 6291455,
  parameter int LIM_LO     = -6291456
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   res_valid,
  input  logic signed [IN_W-1:0] res_data,
  input  logic                   res_ovf,
  input  logic                   rd_start,
  input  logic                   rd_done,
  input  logic                   stat_rd_done,
  input  logic                   sync_in,
  input  logic                   cfg_change,
  input  logic                   pwr_down,
  input  logic                   ext_flag,
  output logic [OUT_W-1:0]       out_word,
  output logic                   out_valid,
  output logic                   acc_flag,
  output logic                   range_flag,
  output logic                   ovwr_flag,
  output logic                   mflg_flag,
  output logic                   settled,
  output logic                   err_flag,
  output logic                   err_n
);

  logic rd_open;
  logic range_hit;
  logic mflg_set;
  logic acc_evt;
  logic ovwr_evt;

  always_ff @(posedge clk) begin
    if (rst)           rd_open <= 1'b0;
    else if (rd_start) rd_open <= 1'b1;
    else if (rd_done)  rd_open <= 1'b0;
  end

  assign acc_evt  = res_valid && res_ovf;
  assign ovwr_evt = res_valid && rd_open;

  adc_word_clip #(.IN_W(IN_W), .OUT_W(OUT_W)) u_clip (
    .clk(clk), .rst(rst), .res_valid(res_valid), .res_data(res_data),
    .res_ovf(res_ovf), .out_word(out_word), .out_valid(out_valid)
  );

  adc_range_watch #(
    .IN_W(IN_W), .RANGE_CNT(RANGE_CNT), .LIM_HI(LIM_HI), .LIM_LO(LIM_LO)
  ) u_range (
    .clk(clk), .rst(rst), .res_valid(res_valid), .res_data(res_data),
    .range_hit(range_hit)
  );

  adc_settle_track #(.SETTLE_CNT(SETTLE_CNT)) u_settle (
    .clk(clk), .rst(rst), .res_valid(res_valid), .sync_in(sync_in),
    .cfg_change(cfg_change), .pwr_down(pwr_down), .mflg_set(mflg_set),
    .settled(settled)
  );

  adc_err_flags u_flags (
    .clk(clk), .rst(rst), .settled(settled), .pwr_down(pwr_down),
    .stat_clr(stat_rd_done), .acc_evt(acc_evt), .rng_evt(range_hit),
    .ovwr_evt(ovwr_evt), .ext_flag(ext_flag), .mflg_set(mflg_set),
    .acc_flag(acc_flag), .range_flag(range_flag), .ovwr_flag(ovwr_flag),
    .mflg_flag(mflg_flag), .err_flag(err_flag), .err_n(err_n)
  );

  p_read_open_r4: assert property (@(posedge clk) disable iff (rst)
    rd_start |=> rd_open);
  p_read_close_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_done && !rd_start) |=> !rd_open);

endmodule

// File: tb/adc_status_mon_test.sv
module adc_status_mon_test;

  localparam int CLK_PERIOD = 10;
  localparam int IN_W  = 26;
  localparam int OUT_W = 24;

  logic                   clk = 1'b0;
  logic                   rst = 1'b1;
  logic                   res_valid = 1'b0;
  logic signed [IN_W-1:0] res_data = '0;
  logic                   res_ovf = 1'b0;
  logic                   rd_start = 1'b0;
  logic                   rd_done = 1'b0;
  logic                   stat_rd_done = 1'b0;
  logic                   sync_in = 1'b0;
  logic                   cfg_change = 1'b0;
  logic                   pwr_down = 1'b0;
  logic                   ext_flag = 1'b0;
  logic [OUT_W-1:0]       out_word;
  logic                   out_valid, acc_flag, range_flag, ovwr_flag;
  logic                   mflg_flag, settled, err_flag, err_n;

  int checks = 0;
  int errors = 0;

  adc_status_mon #(.SETTLE_CNT(2)) uut (
    .clk(clk), .rst(rst), .res_valid(res_valid), .res_data(res_data),
    .res_ovf(res_ovf), .rd_start(rd_start), .rd_done(rd_done),
    .stat_rd_done(stat_rd_done), .sync_in(sync_in), .cfg_change(cfg_change),
    .pwr_down(pwr_down), .ext_flag(ext_flag), .out_word(out_word),
    .out_valid(out_valid), .acc_flag(acc_flag), .range_flag(range_flag),
    .ovwr_flag(ovwr_flag), .mflg_flag(mflg_flag), .settled(settled),
    .err_flag(err_flag), .err_n(err_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic send(input longint v, input bit ovf);
    res_valid = 1'b1;
    res_data  = IN_W'(v);
    res_ovf   = ovf;
    cyc();
    res_valid = 1'b0;
    res_ovf   = 1'b0;
  endtask

  task automatic stat_read();
    stat_rd_done = 1'b1;
    cyc();
    stat_rd_done = 1'b0;
  endtask

  function automatic logic [OUT_W-1:0] clip_exp(input longint v, input bit ovf);
    if (ovf) return (v < 0) ? 24'h800000 : 24'h7FFFFF;
    if (v > 8388607) return 24'h7FFFFF;
    if (v < -8388608) return 24'h800000;
    return OUT_W'(v);
  endfunction

  task automatic chk_flags(input string req, input string what,
                           input logic [3:0] exp);
    logic [3:0] act;
    act = {acc_flag, range_flag, ovwr_flag, mflg_flag};
    chk(act == exp, req, what, act, exp);
  endtask

  initial begin
    longint bases[7];
    longint ovs[4];
    bases = '{0, 8388607, -8388608, 6291455, -6291456, 33554431, -33554432};
    ovs   = '{5, -5, 33554431, -33554432};

    repeat (3) cyc();
    // R10 reset state
    chk(out_valid == 0 && out_word == 0, "R10", "out after reset", out_word, 0);
    chk_flags("R10", "flags after reset", 4'b0000);
    chk(settled == 0, "R10", "settled after reset", settled, 0);
    chk(err_flag == 0 && err_n == 1, "R10", "err after reset", err_n, 1);
    rst = 1'b0;

    // R8 settling takes two valid results
    send(0, 0);
    chk(settled == 0, "R8", "settled after 1 result", settled, 0);
    send(0, 0);
    chk(settled == 1, "R8", "settled after 2 results", settled, 1);
    cyc();
    chk(out_valid == 0, "R1", "out_valid idle", out_valid, 0);

    // R1 clipping sweep around every boundary
    for (int b = 0; b < 7; b++) begin
      for (int o = -3; o <= 3; o++) begin
        longint v;
        v = bases[b] + o;
        if (v > 33554431 || v < -33554432) continue;
        send(v, 0);
        chk(out_valid == 1 && out_word == clip_exp(v, 0), "R1", "clip word",
            out_word, clip_exp(v, 0));
      end
    end
    chk(acc_flag == 0, "R2", "no acc without overflow", acc_flag, 0);

    // R1/R2/R6 overflow forcing
    for (int k = 0; k < 4; k++) begin
      send(ovs[k], 1);
      chk(out_word == clip_exp(ovs[k], 1), "R1", "overflow word",
          out_word, clip_exp(ovs[k], 1));
      chk(acc_flag == 1, "R2", "acc set", acc_flag, 1);
      chk(err_flag == 1 && err_n == 0, "R6", "err from acc", err_n, 0);
    end
    send(0, 0);

    // R7 status read clears
    stat_read();
    chk_flags("R7", "cleared by status read", 4'b0000);
    chk(err_flag == 0 && err_n == 1, "R7", "err cleared", err_n, 1);

    // R7 set wins over clear in same cycle
    stat_rd_done = 1'b1;
    send(3, 1);
    stat_rd_done = 1'b0;
    chk(acc_flag == 1, "R7", "set wins over clear", acc_flag, 1);
    stat_read();

    // R3 range runs
    for (int i = 0; i < 3; i++) send(6291456, 0);
    chk(range_flag == 0, "R3", "three high", range_flag, 0);
    send(6291456, 0);
    chk(range_flag == 1, "R3", "four high", range_flag, 1);
    chk(err_flag == 0 && err_n == 1, "R6", "range not in error", err_n, 1);
    send(0, 0);
    stat_read();
    for (int i = 0; i < 4; i++) send(6291455, 0);
    chk(range_flag == 0, "R3", "limit value is in range", range_flag, 0);
    for (int i = 0; i < 4; i++) send(-6291456, 0);
    chk(range_flag == 0, "R3", "low limit in range", range_flag, 0);
    for (int i = 0; i < 3; i++) send(-6291457, 0);
    send(6291456, 0);
    for (int i = 0; i < 3; i++) send(-6291457, 0);
    chk(range_flag == 0, "R3", "polarity flip restarts", range_flag, 0);
    cyc();
    send(-6291457, 0);
    chk(range_flag == 1, "R3", "four low across idle gap", range_flag, 1);
    send(0, 0);
    stat_read();
    for (int i = 0; i < 3; i++) send(7000000, 0);
    send(0, 0);
    for (int i = 0; i < 3; i++) send(7000000, 0);
    chk(range_flag == 0, "R3", "in-range restarts", range_flag, 0);
    send(0, 0);

    // R4 overwrite
    rd_start = 1'b1; cyc(); rd_start = 1'b0;
    send(1, 0);
    chk(ovwr_flag == 1, "R4", "overwrite during read", ovwr_flag, 1);
    chk(err_flag == 1 && err_n == 0, "R6", "err from ovwr", err_n, 0);
    stat_read();
    rd_done = 1'b1; cyc(); rd_done = 1'b0;
    send(1, 0);
    chk(ovwr_flag == 0, "R4", "no overwrite after done", ovwr_flag, 0);
    rd_start = 1'b1; rd_done = 1'b1; cyc(); rd_start = 1'b0; rd_done = 1'b0;
    send(1, 0);
    chk(ovwr_flag == 1, "R4", "start wins over done", ovwr_flag, 1);
    rd_done = 1'b1; cyc(); rd_done = 1'b0;
    stat_read();
    chk_flags("R7", "clear after ovwr", 4'b0000);

    // R9 freeze while unsettled
    send(9, 1);
    sync_in = 1'b1; cyc(); sync_in = 1'b0;
    chk(settled == 0, "R8", "sync drops settled", settled, 0);
    stat_read();
    chk(acc_flag == 1, "R9", "status read ignored unsettled", acc_flag, 1);
    rd_start = 1'b1; cyc(); rd_start = 1'b0;
    ext_flag = 1'b1;
    send(-9, 1);
    ext_flag = 1'b0;
    chk_flags("R9", "frozen unsettled", 4'b1000);
    chk(out_word == 24'h800000, "R1", "clip while unsettled", out_word, 24'h800000);
    send(0, 0);
    chk(settled == 1, "R8", "resettled after sync", settled, 1);
    chk(ovwr_flag == 0, "R9", "ovwr frozen at settle edge", ovwr_flag, 0);
    rd_done = 1'b1; cyc(); rd_done = 1'b0;
    stat_read();
    chk_flags("R7", "clear after resettle", 4'b0000);

    // R5 external flag
    ext_flag = 1'b1; cyc(); ext_flag = 1'b0;
    chk(mflg_flag == 1, "R5", "mflg captured", mflg_flag, 1);
    chk(settled == 0, "R5", "mflg drops settled", settled, 0);
    chk(err_flag == 1 && err_n == 0, "R6", "err from mflg", err_n, 0);
    stat_read();
    chk(mflg_flag == 1, "R9", "mflg held unsettled", mflg_flag, 1);
    send(0, 0); send(0, 0);
    stat_read();
    chk(mflg_flag == 0, "R7", "mflg cleared", mflg_flag, 0);

    // R8 configuration change
    cfg_change = 1'b1; cyc(); cfg_change = 1'b0;
    chk(settled == 0, "R8", "cfg drops settled", settled, 0);
    send(0, 0); send(0, 0);
    chk(settled == 1, "R8", "resettled after cfg", settled, 1);

    // R5/R8 power-down
    ext_flag = 1'b1; pwr_down = 1'b1; cyc();
    chk(mflg_flag == 0, "R5", "ext ignored in power-down", mflg_flag, 0);
    chk(settled == 0, "R8", "power-down drops settled", settled, 0);
    send(0, 0); send(0, 0); send(0, 0);
    chk(settled == 0, "R8", "held low in power-down", settled, 0);
    ext_flag = 1'b0;
    pwr_down = 1'b0;
    send(0, 0);
    chk(settled == 0, "R8", "leave edge not counted", settled, 0);
    send(0, 0);
    chk(settled == 0, "R8", "one after leave", settled, 0);
    send(0, 0);
    chk(settled == 1, "R8", "two after leave", settled, 1);
    chk_flags("R5", "no flags after power-down", 4'b0000);

    // R10 reset mid-run
    send(100, 1);
    chk(acc_flag == 1, "R2", "acc before reset", acc_flag, 1);
    rst = 1'b1; cyc(); rst = 1'b0;
    chk_flags("R10", "flags after mid reset", 4'b0000);
    chk(settled == 0 && out_valid == 0 && out_word == 0, "R10",
        "state after mid reset", out_word, 0);
    chk(err_n == 1, "R10", "err_n after mid reset", err_n, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule